// File: doc/BRIEF.md
# Memory Card Access Strobe Sequencer

This block runs one bus cycle at a time on a 16-bit memory-card style interface. The CPU side hands it a request: an address, a read or write flag, a byte or word size and write data. The block pulls the card enables low for the length of the cycle. It asserts either the output enable (for a read) or the write enable (for a write) inside that window. Data moves over two byte lanes: the lower lane carries bits 7..0 and the upper lane carries bits 15..8. At the end of a read the card data is captured, and a one-clock completion pulse is raised for reads and writes alike.

The shortest cycle has two states with the strobe active in both. Two configuration bits each move one strobe edge by one state. The first adds a setup state in which the card enable is low but the strobe is not yet asserted. The second adds a hold state after the strobe is negated, in which the card enable stays low. With one bit set the cycle is three states long, and with both set it is four. An active-low wait input, sampled in the last strobe state, stretches the strobe for as long as it is held low.

Top module: `memcard_strobe_seq`

## Requirements
- R1: After reset, and whenever idle, `ce1N`, `ce2N`, `oeN` and `weN` are high, `dataOe` and `done` are low, and `reqReady` is high.
- R2: With both shift bits low, the strobe goes low in the first clock after acceptance, together with `ce1N`. It stays low for exactly two clocks when no wait is applied, and `ce1N` rises together with the strobe.
- R3: With `cfgLateAssert` high at acceptance, `ce1N` is low for exactly one clock before the strobe goes low.
- R4: With `cfgLateNegate` high at acceptance, `ce1N` stays low for exactly one clock after the strobe rises.
- R5: With both shift bits high, the cycle is four clocks long: one setup clock, two strobe clocks and one hold clock.
- R6: Each rising clock edge in the last strobe state at which `waitN` is sampled low keeps the strobe low for one more clock. `waitN` has no effect in any other state.
- R7: `oeN` goes low only on reads and `weN` only on writes, and the two are never low together.
- R8: A word access (`reqWord`=1) drives both `ce1N` and `ce2N` low and forces `cardAddr[0]` to 0. On a write, the lower lane carries `reqWdata[7:0]` and the upper lane carries `reqWdata[15:8]`. On a read, `rdData` equals `dataIn`.
- R9: A byte access (`reqWord`=0) drives only `ce1N` low and passes the full request address, including bit 0, to `cardAddr`. A write places `reqWdata[7:0]` on the lower lane for both even and odd addresses. A read returns `{8'h00, dataIn[7:0]}`, so the upper input lane is ignored.
- R10: `done` is high for exactly one clock: the first clock after the strobe rises. This falls in the hold state when `cfgLateNegate` was set and in idle otherwise. `rdData` takes its new value in the same clock.
- R11: A request is taken only at a rising edge where `reqValid` and `reqReady` are both high. A `reqValid` pulse during a busy cycle starts no cycle, and `cardAddr` stays unchanged while `ce1N` is low.
- R12: `dataOe` is high for exactly the clocks in which `ce1N` is low during a write cycle, and low during read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle; a request is taken at the next edge |
| reqAddr | input | ADDR_W | Request byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit access, 0 = byte |
| reqWdata | input | 2*LANE_W | Write data; a byte write uses bits 7..0 |
| cfgLateAssert | input | 1 | Delay strobe assertion by one state |
| cfgLateNegate | input | 1 | Keep the card enable low one state after the strobe |
| waitN | input | 1 | Active-low wait, sampled in the last strobe state |
| cardAddr | output | ADDR_W | Card address |
| ce1N | output | 1 | Active-low card enable, lower lane |
| ce2N | output | 1 | Active-low card enable, upper lane |
| oeN | output | 1 | Active-low output enable (reads) |
| weN | output | 1 | Active-low write enable (writes) |
| dataOut | output | 2*LANE_W | Data driven toward the card |
| dataOe | output | 1 | Drive enable for dataOut |
| dataIn | input | 2*LANE_W | Data returned by the card |
| rdData | output | 2*LANE_W | Captured read data |
| done | output | 1 | One-clock completion pulse |

## Verification
Cycles are run under all four combinations of the shift bits, so a wrong setup or hold length shows up as a wrong count of card-enable clocks on either side of the strobe. Wait lengths of zero, one and three show whether the stretch happens only in the final strobe state. Word and byte accesses at even and odd addresses, in both directions, show up lane swaps, a wrongly asserted second enable, and a wrong address bit 0. Byte reads are driven with garbage on the upper input lane to prove it is ignored. A stray request pulse during a busy cycle and back-to-back requests show whether acceptance is limited to idle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_STRB1 = 3'd2,
    ST_STRB2 = 3'd3,
    ST_HOLD  = 3'd4
  } mcs_state_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic accept;    // latch request this edge
    logic ceOn;      // card enable window
    logic strobeOn;  // OE or WE window
    logic capture;   // last strobe edge, wait released
  } mcs_ctl_t;

endpackage

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     cfgLateAssert,
  input  logic     cfgLateNegate,
  input  logic     waitN,
  output logic     ready,
  output mcs_ctl_t ctl
);

  mcs_state_e state, stateNxt;
  logic lateNegQ;

  always_comb begin
    ready        = (state == ST_IDLE);
    ctl.accept   = ready && reqValid;
    ctl.ceOn     = (state != ST_IDLE);
    ctl.strobeOn = (state == ST_STRB1) || (state == ST_STRB2);
    ctl.capture  = (state == ST_STRB2) && waitN;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNxt = cfgLateAssert ? ST_SETUP : ST_STRB1;
      ST_SETUP: stateNxt = ST_STRB1;
      ST_STRB1: stateNxt = ST_STRB2;
      ST_STRB2: if (waitN) stateNxt = lateNegQ ? ST_HOLD : ST_IDLE;
      ST_HOLD:  stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lateNegQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.accept) lateNegQ <= cfgLateNegate;
    end
  end

  // R6: a low wait in the final strobe state holds that state
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STRB2 && !waitN) |=> (state == ST_STRB2));

  // R3: setup state always leads into the strobe
  p_setup_to_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP) |=> (state == ST_STRB1));

  // R2: strobe always covers at least two states
  p_two_strobe_states_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STRB1) |=> (state == ST_STRB2));

  // R4: hold state lasts one clock then returns to idle
  p_hold_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |=> (state == ST_IDLE));

endmodule

// File: rtl/mcs_datapath.sv
module mcs_datapath
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  mcs_ctl_t            ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqWord,
  input  logic [2*LANE_W-1:0] reqWdata,
  input  logic [2*LANE_W-1:0] dataIn,
  output logic [ADDR_W-1:0]   cardAddr,
  output logic                ce1N,
  output logic                ce2N,
  output logic                oeN,
  output logic                weN,
  output logic [2*LANE_W-1:0] dataOut,
  output logic                dataOe,
  output logic [2*LANE_W-1:0] rdData,
  output logic                done
);

  localparam int BUS_W = 2 * LANE_W;
  localparam int NLANE = 2;

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic              wordQ;
  logic [BUS_W-1:0]  wdataQ;
  logic [BUS_W-1:0]  rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      wordQ  <= 1'b0;
      wdataQ <= '0;
    end else if (ctl.accept) begin
      addrQ  <= reqWord ? {reqAddr[ADDR_W-1:1], 1'b0} : reqAddr;
      writeQ <= reqWrite;
      wordQ  <= reqWord;
      wdataQ <= reqWdata;
    end
  end

  // Lane steering: byte traffic always rides the lower lane
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign dataOut[l*LANE_W +: LANE_W] =
      wordQ ? wdataQ[l*LANE_W +: LANE_W] : wdataQ[0 +: LANE_W];
    if (l == 0) begin : g_low
      assign rdNext[l*LANE_W +: LANE_W] = dataIn[l*LANE_W +: LANE_W];
    end else begin : g_high
      assign rdNext[l*LANE_W +: LANE_W] =
        wordQ ? dataIn[l*LANE_W +: LANE_W] : '0;
    end
  end

  always_comb begin
    cardAddr = addrQ;
    ce1N     = !ctl.ceOn;
    ce2N     = !(ctl.ceOn && wordQ);
    oeN      = !(ctl.strobeOn && !writeQ);
    weN      = !(ctl.strobeOn && writeQ);
    dataOe   = ctl.ceOn && writeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctl.capture;
      if (ctl.capture && !writeQ) rdData <= rdNext;
    end
  end

  // R7: output enable and write enable never overlap
  p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));

  // R8: upper enable only inside the lower-enable window
  p_ce2_within_ce1_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ce2N |-> !ce1N);

  // R10: completion pulse is a single clock
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: address stays put for the whole enable window
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!ce1N && $past(!ce1N)) |-> $stable(cardAddr));

  // R7: strobes only inside the card-enable window
  p_strobe_in_ce_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN || !weN) |-> !ce1N);

endmodule

// File: rtl/memcard_strobe_seq.sv
module memcard_strobe_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqWord,
  input  logic [2*LANE_W-1:0] reqWdata,
  input  logic                cfgLateAssert,
  input  logic                cfgLateNegate,
  input  logic                waitN,
  output logic [ADDR_W-1:0]   cardAddr,
  output logic                ce1N,
  output logic                ce2N,
  output logic                oeN,
  output logic                weN,
  output logic [2*LANE_W-1:0] dataOut,
  output logic                dataOe,
  input  logic [2*LANE_W-1:0] dataIn,
  output logic [2*LANE_W-1:0] rdData,
  output logic                done
);

  mcs_ctl_t ctl;

  mcs_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .cfgLateAssert (cfgLateAssert),
    .cfgLateNegate (cfgLateNegate),
    .waitN         (waitN),
    .ready         (reqReady),
    .ctl           (ctl)
  );

  mcs_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .reqWdata (reqWdata),
    .dataIn   (dataIn),
    .cardAddr (cardAddr),
    .ce1N     (ce1N),
    .ce2N     (ce2N),
    .oeN      (oeN),
    .weN      (weN),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .rdData   (rdData),
    .done     (done)
  );

endmodule

// File: tb/tb_memcard_strobe_seq.sv
`timescale 1ns/1ps
module tb_memcard_strobe_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqWord = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        cfgLateAssert = 1'b0;
  logic        cfgLateNegate = 1'b0;
  logic        waitN = 1'b1;
  logic [15:0] cardAddr;
  logic        ce1N, ce2N, oeN, weN, dataOe, done;
  logic [15:0] dataOut, rdData;
  logic [15:0] dataIn = '0;

  always #5 clk = ~clk;

  memcard_strobe_seq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWord(reqWord),
    .reqWdata(reqWdata), .cfgLateAssert(cfgLateAssert),
    .cfgLateNegate(cfgLateNegate), .waitN(waitN), .cardAddr(cardAddr),
    .ce1N(ce1N), .ce2N(ce2N), .oeN(oeN), .weN(weN), .dataOut(dataOut),
    .dataOe(dataOe), .dataIn(dataIn), .rdData(rdData), .done(done)
  );

  typedef struct {
    bit          wr;
    bit          word;
    bit          lateA;
    bit          lateN;
    int          waits;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdExp;
  } item_t;

  item_t q[$];
  int nChecks = 0, nFail = 0;
  int issued = 0, completed = 0;
  int waitsLeft = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // Driver: issue one request and push its expectation
  task automatic xfer(input bit wr, input bit word, input bit la, input bit ln,
                      input int waits, input logic [15:0] addr,
                      input logic [15:0] wd, input logic [15:0] cardIn,
                      input bit stray);
    item_t e;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    e.wr = wr; e.word = word; e.lateA = la; e.lateN = ln; e.waits = waits;
    e.addr = word ? {addr[15:1], 1'b0} : addr;
    e.wdata = wd;
    e.rdExp = word ? cardIn : {8'h00, cardIn[7:0]};
    q.push_back(e);
    issued++;
    waitsLeft = waits;
    dataIn = cardIn;
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr; reqWord = word;
    reqWdata = wd; cfgLateAssert = la; cfgLateNegate = ln;
    @(negedge clk);
    reqValid = 1'b0;
    if (stray) begin
      // R11: pulse while busy must be ignored
      reqValid = 1'b1; reqAddr = addr ^ 16'h0F0F; reqWrite = !wr;
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // Monitor: measure each card-enable window and compare to the queue
  bit inCycle = 0, prevDone = 0;
  int lead, strb, tail, doneCnt;
  bit oeSeen, weSeen, ce2Seen, doneInCe, addrStable, dataOeHi, dataOeLo;
  logic [15:0] addr0, wrLanes, rdSeen;

  initial begin
    item_t e;
    bit strobe;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      strobe = !oeN || !weN;
      if (!ce1N) begin
        if (!inCycle) begin
          inCycle = 1; lead = 0; strb = 0; tail = 0; doneCnt = 0;
          oeSeen = 0; weSeen = 0; ce2Seen = 0; doneInCe = 0;
          addrStable = 1; dataOeHi = 0; dataOeLo = 0;
          addr0 = cardAddr; wrLanes = 'x;
        end
        if (strobe) strb++;
        else if (strb == 0) lead++;
        else tail++;
        if (!oeN) oeSeen = 1;
        if (!weN) begin weSeen = 1; wrLanes = dataOut; end
        if (!ce2N) ce2Seen = 1;
        if (cardAddr != addr0) addrStable = 0;
        if (dataOe) dataOeHi = 1; else dataOeLo = 1;
        chk(!(!oeN && !weN), "R7", "oeN and weN both low", 32'(oeN), 32'(weN));
      end
      if (done) begin
        chk(!prevDone, "R10", "done high two clocks", 1, 0);
        doneCnt++; doneInCe = !ce1N; rdSeen = rdData;
        chk(!strobe, "R10", "done during strobe", 32'(strobe), 0);
      end
      prevDone = done;
      if (ce1N && inCycle) begin
        inCycle = 0;
        completed++;
        if (q.size() == 0) begin
          chk(0, "R11", "cycle with no request", 1, 0);
        end else begin
          e = q.pop_front();
          chk(lead == int'(e.lateA), e.lateA ? "R3" : "R2", "setup clocks", lead, e.lateA);
          chk(strb == 2 + e.waits, e.waits > 0 ? "R6" : "R2", "strobe clocks", strb, 2 + e.waits);
          chk(tail == int'(e.lateN), (e.lateA && e.lateN) ? "R5" : "R4", "hold clocks", tail, e.lateN);
          chk(oeSeen == !e.wr && weSeen == e.wr, "R7", "strobe kind", {oeSeen, weSeen}, {!e.wr, e.wr});
          chk(ce2Seen == e.word, e.word ? "R8" : "R9", "ce2N usage", ce2Seen, e.word);
          chk(addr0 == e.addr, e.word ? "R8" : "R9", "cardAddr", addr0, e.addr);
          chk(addrStable, "R11", "cardAddr moved", 0, 1);
          chk(doneCnt == 1, "R10", "done count", doneCnt, 1);
          chk(doneInCe == e.lateN, "R10", "done placement", doneInCe, e.lateN);
          chk(dataOeHi == e.wr && dataOeLo == !e.wr, "R12", "dataOe window",
              {dataOeHi, dataOeLo}, {e.wr, !e.wr});
          chk(dataOe == 0, "R12", "dataOe after cycle", dataOe, 0);
          if (e.wr) begin
            chk(wrLanes[7:0] == e.wdata[7:0], e.word ? "R8" : "R9", "lower lane", wrLanes[7:0], e.wdata[7:0]);
            if (e.word)
              chk(wrLanes[15:8] == e.wdata[15:8], "R8", "upper lane", wrLanes[15:8], e.wdata[15:8]);
          end else begin
            chk(rdSeen == e.rdExp, e.word ? "R8" : "R9", "rdData", rdSeen, e.rdExp);
          end
        end
      end
      // Wait injection: only once the final strobe state is reached
      if (strobe && strb >= 2 && waitsLeft > 0) begin
        waitN = 1'b0; waitsLeft--;
      end else if (!strobe && !ce1N && waitsLeft > 0) begin
        waitN = 1'b0;  // R6: low outside the last strobe state has no effect
      end else begin
        waitN = 1'b1;
      end
    end
  end

  initial begin
    #2_000_000;
    chk(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(ce1N && ce2N, "R1", "card enables idle", {ce1N, ce2N}, 2'b11);
    chk(oeN && weN, "R1", "strobes idle", {oeN, weN}, 2'b11);
    chk(!dataOe && !done, "R1", "dataOe/done idle", {dataOe, done}, 0);
    chk(reqReady, "R1", "ready after reset", reqReady, 1);

    // wr word lateA lateN waits addr wdata cardIn stray
    xfer(0, 1, 0, 0, 0, 16'h1000, 16'h0, 16'hBEEF, 0);  // R2 R8 word read
    xfer(1, 1, 0, 0, 0, 16'h1235, 16'hA1B2, 16'h0, 0);  // R8 word write, odd addr forced even
    xfer(0, 0, 1, 0, 0, 16'h2001, 16'h0, 16'h5A3C, 0);  // R3 R9 odd byte read, upper garbage
    xfer(0, 0, 0, 1, 0, 16'h2002, 16'h0, 16'hC3E7, 0);  // R4 R9 even byte read
    xfer(1, 0, 1, 1, 0, 16'h3003, 16'h77C4, 16'h0, 0);  // R5 R9 odd byte write
    xfer(1, 0, 0, 0, 1, 16'h3004, 16'h1299, 16'h0, 0);  // R6 one wait, even byte write
    xfer(0, 1, 1, 1, 3, 16'h4000, 16'h0, 16'h0123, 0);  // R5 R6 three waits
    xfer(0, 1, 0, 1, 2, 16'h4444, 16'h0, 16'hFEDC, 1);  // R11 stray pulse while busy
    xfer(1, 1, 1, 0, 0, 16'h5556, 16'h8421, 16'h0, 0);  // R12 write window with setup
    xfer(0, 0, 0, 0, 0, 16'h6007, 16'h0, 16'hFF00, 0);  // R9 upper lane ignored
    xfer(1, 1, 0, 0, 2, 16'h7008, 16'hDEAD, 16'h0, 1);  // R11 R6 stray during write
    xfer(0, 1, 1, 1, 0, 16'h8000, 16'h0, 16'h6B6B, 0);  // R5 back-to-back

    repeat (20) @(negedge clk);
    chk(completed == issued, "R11", "cycle count", completed, issued);
    chk(q.size() == 0, "R11", "unfinished items", q.size(), 0);
    chk(ce1N && oeN && weN && reqReady, "R1", "idle at end",
        {ce1N, oeN, weN, reqReady}, 4'hF);
    summary();
  end

endmodule